// File: doc/BRIEF.md
# Rail Undervoltage and Thermal Fault Supervisor

This block is the fault decision logic of a multi-rail power controller. It takes undervoltage comparator flags for each regulated output rail, undervoltage flags for the main supply inputs, and two temperature comparator flags. From these it drives one fault indication and a shutdown request for each regulator. It also drives a chip-wide latch-off and a request to fall back to the deepest sleep state. All comparator flags are asynchronous and pass through two-flop synchronisers. Comparator hysteresis is handled outside the block.

The response to an undervoltage depends on how the rail is powered. A rail driven through an external pass device only reports the fault. A rail driven through an on-chip pass device also latches its own regulator off. During the first startup phase, an undervoltage on either standby rail latches the whole chip off, and only a power-on reset clears that. Temperature is handled in two levels. The warning level only reports. The critical level turns every output off, and the outputs stay off until the temperature has fallen below the warning level again. The shutdown request turns all outputs off while it is held, pulls the fault output low, and clears every per-regulator latch.

Top module: `rail_fault_supervisor`

## Requirements
- R1: After por_n is released, fault_o, rail_dis_o, global_off_o and force_s5_o are all 0. A later por_n pulse returns them to 0, including a set global_off_o.
- R2: fault_o is 1 while any of the following is present: an armed rail undervoltage, any main_uv_i bit, temp_warn_i, temp_crit_i, or a set global_off_o. Shutdown is the exception.
- R3: An undervoltage on an armed rail whose rail_int_i bit is 0 (external pass device) sets fault_o only. rail_dis_o is unchanged.
- R4: An undervoltage on an armed rail whose rail_int_i bit is 1 (on-chip pass device) sets bit i of rail_dis_o. Rail i maps to bit i of every rail vector. The bit stays set after the undervoltage clears, and no other bit is set.
- R5: An armed undervoltage on a standby rail (STBY_MASK bit set, rails 0 and 1 by default) while startup_i is 1 sets global_off_o. global_off_o forces all rail_dis_o bits to 1. It survives shutdown and is cleared only by por_n.
- R6: temp_warn_i alone sets fault_o only. temp_crit_i forces all rail_dis_o bits to 1. They stay forced while temp_warn_i remains 1 and are released once both temperature flags are 0.
- R7: Any main_uv_i bit while active_i is 1 sets force_s5_o. force_s5_o stays set while any main_uv_i bit is 1 and clears when all bits are 0. A main input undervoltage while active_i is 0 sets fault_o but not force_s5_o.
- R8: While shut_i is 1, all rail_dis_o bits are 1, fault_o is 0 and force_s5_o is 0. The per-regulator latches are cleared, so after release rail_dis_o follows only new events.
- R9: An undervoltage on a rail whose rail_arm_i bit is 0 has no effect on fault_o or rail_dis_o.
- R10: A comparator flag change reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages plus one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| shut_i | input | 1 | Shutdown request, active high, synchronous |
| rail_uv_i | input | N_RAIL | Per-rail undervoltage comparator flags (asynchronous) |
| rail_arm_i | input | N_RAIL | Per-rail monitor armed |
| rail_int_i | input | N_RAIL | Per-rail pass type: 1 on-chip, 0 external |
| main_uv_i | input | N_MAIN | Main supply undervoltage flags (asynchronous) |
| active_i | input | 1 | System is in an active power state |
| startup_i | input | 1 | First startup phase in progress |
| temp_warn_i | input | 1 | Temperature warning comparator (asynchronous) |
| temp_crit_i | input | 1 | Critical temperature comparator (asynchronous) |
| fault_o | output | 1 | Combined fault indication |
| rail_dis_o | output | N_RAIL | Per-regulator disable |
| global_off_o | output | 1 | Chip-wide latch-off |
| force_s5_o | output | 1 | Request to enter the deepest sleep state |

## Verification
The shutdown request can arrive in the same cycle as a rail undervoltage on an on-chip pass rail. It can also arrive while a main input undervoltage holds force_s5_o set. The bench provokes both cases by holding shut_i together with those comparator flags. It expects fault_o and force_s5_o low, all disables high, and no per-regulator latch left behind after release. A critical temperature that falls back to the warning level is judged the same way: it must keep all disables forced until the warning also clears.

// File: rtl/rail_fault_pkg.sv
package rail_fault_pkg;

    typedef enum logic [1:0] {
        THERM_OK   = 2'd0,
        THERM_WARN = 2'd1,
        THERM_HOT  = 2'd2
    } therm_e;

    function automatic therm_e therm_next(therm_e cur, logic warn, logic crit);
        if (crit)
            return THERM_HOT;
        else if (warn)
            return (cur == THERM_HOT) ? THERM_HOT : THERM_WARN;
        else
            return THERM_OK;
    endfunction

endpackage

// File: rtl/rail_sync_bank.sv
module rail_sync_bank #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg_q[s] <= '0;
            else if (s == 0)
                stg_q[s] <= d_i;
            else
                stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rail_fault_core.sv
module rail_fault_core
    import rail_fault_pkg::*;
#(
    parameter int                 N_RAIL    = 6,
    parameter int                 N_MAIN    = 3,
    parameter logic [N_RAIL-1:0]  STBY_MASK = 6'b000011
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              shut_i,
    input  logic [N_RAIL-1:0] rail_uv_s,
    input  logic [N_RAIL-1:0] rail_arm_i,
    input  logic [N_RAIL-1:0] rail_int_i,
    input  logic [N_MAIN-1:0] main_uv_s,
    input  logic              active_i,
    input  logic              startup_i,
    input  logic              warn_s,
    input  logic              crit_s,
    output logic              fault_o,
    output logic [N_RAIL-1:0] rail_dis_o,
    output logic              global_off_o,
    output logic              force_s5_o
);
    typedef struct packed {
        logic              shut;
        logic [N_RAIL-1:0] arm;
        logic [N_RAIL-1:0] intp;
        logic              active;
        logic              startup;
        logic [N_RAIL-1:0] reg_off;
        logic              goff;
        logic              s5;
        logic              fault;
        therm_e            therm;
    } st_t;

    st_t st_d, st_q;
    logic [N_RAIL-1:0] uv_eff;
    logic              all_off;

    always_comb begin
        st_d         = st_q;
        st_d.shut    = shut_i;
        st_d.arm     = rail_arm_i;
        st_d.intp    = rail_int_i;
        st_d.active  = active_i;
        st_d.startup = startup_i;
        st_d.therm   = therm_next(st_q.therm, warn_s, crit_s);
        uv_eff       = rail_uv_s & st_q.arm;

        if (st_q.shut) begin
            st_d.reg_off = '0;
            st_d.s5      = 1'b0;
            st_d.fault   = 1'b0;
        end else begin
            st_d.reg_off = st_q.reg_off | (uv_eff & st_q.intp);
            st_d.goff    = st_q.goff | (st_q.startup & (|(uv_eff & STBY_MASK)));
            if (main_uv_s == '0)
                st_d.s5 = 1'b0;
            else if (st_q.active)
                st_d.s5 = 1'b1;
            st_d.fault = (|uv_eff) | (|main_uv_s) | warn_s | crit_s | st_d.goff;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{shut: 1'b0, arm: '0, intp: '0, active: 1'b0, startup: 1'b0,
                      reg_off: '0, goff: 1'b0, s5: 1'b0, fault: 1'b0, therm: THERM_OK};
        end else begin
            st_q <= st_d;
        end
    end

    assign all_off      = st_q.shut | st_q.goff | (st_q.therm == THERM_HOT);
    assign rail_dis_o   = {N_RAIL{all_off}} | st_q.reg_off;
    assign fault_o      = st_q.fault;
    assign global_off_o = st_q.goff;
    assign force_s5_o   = st_q.s5;

    AST_FAULT_ON_UV: assert property (@(posedge clk) disable iff (!por_n)
        ((|(rail_uv_s & st_q.arm)) && !st_q.shut) |=> fault_o); // R2
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        !st_q.shut |=> ((st_q.reg_off & $past(st_q.reg_off)) == $past(st_q.reg_off))); // R4
    AST_GLOBAL_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        global_off_o |=> global_off_o); // R5
    AST_CRIT_ALL_OFF: assert property (@(posedge clk) disable iff (!por_n)
        crit_s |=> (&rail_dis_o)); // R6
    AST_S5_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(force_s5_o) |-> $past(st_q.active)); // R7
    AST_SHUT_FAULT_LOW: assert property (@(posedge clk) disable iff (!por_n)
        st_q.shut |=> (!fault_o && !force_s5_o)); // R8
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
    parameter int                 N_RAIL      = 6,
    parameter int                 N_MAIN      = 3,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [N_RAIL-1:0]  STBY_MASK   = 6'b000011
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              shut_i,
    input  logic [N_RAIL-1:0] rail_uv_i,
    input  logic [N_RAIL-1:0] rail_arm_i,
    input  logic [N_RAIL-1:0] rail_int_i,
    input  logic [N_MAIN-1:0] main_uv_i,
    input  logic              active_i,
    input  logic              startup_i,
    input  logic              temp_warn_i,
    input  logic              temp_crit_i,
    output logic              fault_o,
    output logic [N_RAIL-1:0] rail_dis_o,
    output logic              global_off_o,
    output logic              force_s5_o
);
    localparam int CMP_W = N_RAIL + N_MAIN + 2;

    logic [CMP_W-1:0]  cmp_s;
    logic [N_RAIL-1:0] rail_uv_s;
    logic [N_MAIN-1:0] main_uv_s;
    logic              warn_s, crit_s;

    rail_sync_bank #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   ({temp_crit_i, temp_warn_i, main_uv_i, rail_uv_i}),
        .q_o   (cmp_s)
    );

    assign {crit_s, warn_s, main_uv_s, rail_uv_s} = cmp_s;

    rail_fault_core #(.N_RAIL(N_RAIL), .N_MAIN(N_MAIN), .STBY_MASK(STBY_MASK)) u_core (
        .clk          (clk),
        .por_n        (por_n),
        .shut_i       (shut_i),
        .rail_uv_s    (rail_uv_s),
        .rail_arm_i   (rail_arm_i),
        .rail_int_i   (rail_int_i),
        .main_uv_s    (main_uv_s),
        .active_i     (active_i),
        .startup_i    (startup_i),
        .warn_s       (warn_s),
        .crit_s       (crit_s),
        .fault_o      (fault_o),
        .rail_dis_o   (rail_dis_o),
        .global_off_o (global_off_o),
        .force_s5_o   (force_s5_o)
    );
endmodule

// File: tb/rail_fault_supervisor_bench.sv
module rail_fault_supervisor_bench;
    localparam int NR = 6;
    localparam int NM = 3;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          shut_i = 1'b0;
    logic [NR-1:0] rail_uv_i = '0;
    logic [NR-1:0] rail_arm_i = '1;
    logic [NR-1:0] rail_int_i = 6'b010110;
    logic [NM-1:0] main_uv_i = '0;
    logic          active_i = 1'b1;
    logic          startup_i = 1'b0;
    logic          temp_warn_i = 1'b0;
    logic          temp_crit_i = 1'b0;
    logic          fault_o, global_off_o, force_s5_o;
    logic [NR-1:0] rail_dis_o;

    always #4 clk = ~clk;

    rail_fault_supervisor u_rail_fault_supervisor (
        .clk(clk), .por_n(por_n), .shut_i(shut_i), .rail_uv_i(rail_uv_i),
        .rail_arm_i(rail_arm_i), .rail_int_i(rail_int_i), .main_uv_i(main_uv_i),
        .active_i(active_i), .startup_i(startup_i), .temp_warn_i(temp_warn_i),
        .temp_crit_i(temp_crit_i), .fault_o(fault_o), .rail_dis_o(rail_dis_o),
        .global_off_o(global_off_o), .force_s5_o(force_s5_o)
    );

    typedef struct {
        logic          fault;
        logic [NR-1:0] dis;
        logic          goff;
        logic          s5;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    event mon_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // monitor: pops the expected item and compares it with the outputs
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (fault_o !== e.fault || rail_dis_o !== e.dis ||
                    global_off_o !== e.goff || force_s5_o !== e.s5) begin
                    n_fail++;
                    $display("FAIL %s: got fault=%b dis=%b goff=%b s5=%b, expected fault=%b dis=%b goff=%b s5=%b",
                             e.tag, fault_o, rail_dis_o, global_off_o, force_s5_o,
                             e.fault, e.dis, e.goff, e.s5);
                end
            end
        end
    end

    // driver side: push the expectation, then wake the monitor
    task automatic expect_now(input logic f, input logic [NR-1:0] d,
                              input logic g, input logic s, input string tag);
        exp_t e;
        e.fault = f; e.dis = d; e.goff = g; e.s5 = s; e.tag = tag;
        exp_q.push_back(e);
        ->mon_ev;
        #0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        settle();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_por();
        expect_now(0, 6'b000000, 0, 0, "R1 reset state");

        // R3: external pass rail 3
        rail_uv_i = 6'b001000; settle();
        expect_now(1, 6'b000000, 0, 0, "R3 external rail fault only");
        rail_uv_i = '0; settle();
        expect_now(0, 6'b000000, 0, 0, "R3 external rail recovered");

        // R4: internal pass rail 2, latched
        rail_uv_i = 6'b000100; settle();
        expect_now(1, 6'b000100, 0, 0, "R4 internal rail latched");
        rail_uv_i = '0; settle();
        expect_now(0, 6'b000100, 0, 0, "R4 latch held after recovery");

        // R9: unarmed internal rail 4 ignored
        rail_arm_i = 6'b101111; settle();
        rail_uv_i = 6'b010000; settle();
        expect_now(0, 6'b000100, 0, 0, "R9 unarmed rail ignored");
        rail_uv_i = '0; rail_arm_i = '1; settle();

        // R8: shutdown in the same window as a new internal-rail UV
        shut_i = 1'b1; rail_uv_i = 6'b010000; settle();
        expect_now(0, 6'b111111, 0, 0, "R8 shutdown wins over rail UV");
        rail_uv_i = '0; settle();
        shut_i = 1'b0; settle();
        expect_now(0, 6'b000000, 0, 0, "R8 latches cleared after release");

        // R7: main input loss while active
        main_uv_i = 3'b010; settle();
        expect_now(1, 6'b000000, 0, 1, "R7 main UV forces S5");
        main_uv_i = 3'b001; settle();
        expect_now(1, 6'b000000, 0, 1, "R7 request held while a main UV remains");
        main_uv_i = '0; settle();
        expect_now(0, 6'b000000, 0, 0, "R7 request cleared on recovery");
        active_i = 1'b0; main_uv_i = 3'b100; settle();
        expect_now(1, 6'b000000, 0, 0, "R7 main UV while inactive: fault only");
        main_uv_i = '0; settle();
        active_i = 1'b1; settle();

        // R8: shutdown with force_s5 set
        main_uv_i = 3'b100; settle();
        expect_now(1, 6'b000000, 0, 1, "R2 main UV raises fault");
        shut_i = 1'b1; settle();
        expect_now(0, 6'b111111, 0, 0, "R8 shutdown clears S5 request");
        main_uv_i = '0; settle();
        shut_i = 1'b0; settle();
        expect_now(0, 6'b000000, 0, 0, "R8 release with no events");

        // R6: thermal levels
        temp_warn_i = 1'b1; settle();
        expect_now(1, 6'b000000, 0, 0, "R6 warning fault only");
        temp_crit_i = 1'b1; settle();
        expect_now(1, 6'b111111, 0, 0, "R6 critical shuts all");
        temp_crit_i = 1'b0; settle();
        expect_now(1, 6'b111111, 0, 0, "R6 stays off until below warning");
        temp_warn_i = 1'b0; settle();
        expect_now(0, 6'b000000, 0, 0, "R6 resumes below warning");

        // R10: latency of a comparator edge
        rail_uv_i = 6'b010000;
        repeat (2) @(negedge clk);
        expect_now(0, 6'b000000, 0, 0, "R10 not visible after two edges");
        @(negedge clk);
        expect_now(1, 6'b010000, 0, 0, "R10 visible after third edge");
        rail_uv_i = '0; settle();

        // R5: standby rail UV during startup
        startup_i = 1'b1; settle();
        rail_uv_i = 6'b000001; settle();
        expect_now(1, 6'b111111, 1, 0, "R5 startup standby UV latches chip off");
        rail_uv_i = '0; startup_i = 1'b0; settle();
        expect_now(1, 6'b111111, 1, 0, "R5 latch-off persists");
        shut_i = 1'b1; settle();
        expect_now(0, 6'b111111, 1, 0, "R5 shutdown does not clear latch-off");
        shut_i = 1'b0; settle();
        expect_now(1, 6'b111111, 1, 0, "R5 latch-off after shutdown release");
        do_por();
        expect_now(0, 6'b000000, 0, 0, "R1 POR clears latch-off");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule